// File: doc/BRIEF.md
# Fixed-Point Euclidean Branch Metric Unit

This unit produces the candidate transition metrics for one step of a four-state recursive systematic convolutional trellis, as used by a soft-output iterative decoder. Each step delivers three received soft samples (the systematic sample and the parity samples of the two constituent encoders) and an a priori reliability for the information bit. The samples are 16-bit sign-magnitude integers that carry the real value multiplied by one hundred. An ideal transmitted symbol is therefore +100 or -100.

For each of the eight transitions (four states times two input bits), the unit forms the squared Euclidean distance between the three observations and the symbols that transition would have sent. It then removes the a priori contribution of the hypothesised bit and presents all eight 32-bit signed metrics in the same cycle, with a valid strobe two clocks after the input strobe. Steps may arrive on consecutive cycles. A frame of four information bits is four such steps. The downstream add-compare-select logic picks survivors from these metrics.

Top module: `euclid_bmu`

## Requirements
- R1: Each input sample is decoded as sign-magnitude: bit 15 is the sign (1 = negative) and bits 14:0 are the magnitude. 0x801E therefore means -30, and 0x8000 (negative zero) behaves exactly like 0x0000.
- R2: A hypothesised code bit of 1 is the symbol +100 and a code bit of 0 is the symbol -100.
- R3: Candidate index k is 2*state + u, with state bits {s1,s0} = k[2:1] and input bit u = k[0]. The feedback bit is a = u ^ s1 ^ s0 and the hypothesised parity is p = a ^ s0. The systematic sample is compared with the symbol for u, and both parity samples are compared with the symbol for p.
- R4: Metric = (sys - hyp_u)^2 + (par1 - hyp_p)^2 + (par2 - hyp_p)^2 - A, where A is the decoded a priori value when u = 1 and minus that value when u = 0.
- R5: Metrics are 32-bit two's complement; candidate k occupies `metrics[32k+31:32k]` (for example, a lone symbol distance of 70 gives 0x00001324).
- R6: A metric above 2^31-1 is clamped to 0x7FFFFFFF, and one below -2^31 to 0x80000000.
- R7: `out_valid` is high in exactly the cycle that follows two rising edges after a cycle with `in_valid` high, and low otherwise; consecutive input steps yield consecutive results.
- R8: Samples presented while `in_valid` is low are ignored: the metrics keep their last value.
- R9: While `rst_n` is low, and after it until the first accepted step emerges, `out_valid` is low and all metrics are zero.
- R10: Candidates that share the same (u, p) pair always present equal metrics: pairs (0,2), (1,3), (4,6) and (5,7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| in_valid | input | 1 | Step strobe: the four samples below are taken this cycle |
| sys_sm | input | 16 | Systematic sample, sign-magnitude, scaled by 100 |
| par1_sm | input | 16 | First constituent parity sample, sign-magnitude |
| par2_sm | input | 16 | Second constituent parity sample, sign-magnitude |
| apri_sm | input | 16 | A priori reliability of the bit, sign-magnitude (0 on the first iteration) |
| out_valid | output | 1 | Metrics below are new this cycle |
| metrics | output | 256 | Eight 32-bit signed metrics, candidate k in bits 32k+31:32k |

## Verification
The bench builds the unit with its default parameters: 16-bit samples, 32-bit metrics, symbol amplitude 100 and trellis memory 2. With these widths, three near full-scale observations push the exact sum past 2^31, so the upper clamp can be reached with ordinary inputs. A full-scale a priori value can turn a metric negative. The eight-candidate trellis also exposes the four pairs of transitions that share a hypothesis, so swapped state bits or a wrong parity equation show up as a broken pair or a misplaced value. Back-to-back steps, idle cycles carrying junk samples, negative zero and a reset while a step is in flight are all driven from the ports.

// File: rtl/euclid_bmu_pkg.sv
`timescale 1ns/1ps
package euclid_bmu_pkg;

  // Hypothesised code bits of one trellis transition.
  typedef struct packed {
    logic u;  // information (systematic) bit
    logic p;  // parity bit
  } code_bits_t;

  // Transition k = {state, u}; state bit 0 is the oldest delay element.
  // Feedback taps on every delay element, feed-forward from the oldest.
  function automatic code_bits_t cand_code(input int unsigned k, input int unsigned mem);
    code_bits_t c;
    logic       fb;
    c.u = k[0];
    fb  = k[0];
    for (int unsigned i = 0; i < mem; i++) begin
      fb = fb ^ k[i+1];
    end
    c.p = fb ^ k[1];
    return c;
  endfunction

endpackage

// File: rtl/sm_to_tc.sv
`timescale 1ns/1ps
// Sign-magnitude to two's complement; negative zero maps to zero.
module sm_to_tc #(
  parameter int W = 16
) (
  input  logic [W-1:0]        sm,
  output logic signed [W-1:0] tc
);
  logic [W-1:0] mag;

  always_comb begin
    mag = {1'b0, sm[W-2:0]};
    if (sm[W-1]) tc = W'(0) - mag;
    else         tc = mag;
  end
endmodule

// File: rtl/obs_sq.sv
`timescale 1ns/1ps
// Squared distance of one observation to both ideal symbols.
module obs_sq #(
  parameter int SAMPLE_W = 16,
  parameter int AMP      = 100,
  localparam int DIFF_W  = SAMPLE_W + 1,
  localparam int SQ_W    = 2 * DIFF_W
) (
  input  logic signed [SAMPLE_W-1:0] obs,
  output logic [SQ_W-1:0]            sq_one,   // distance to +AMP
  output logic [SQ_W-1:0]            sq_zero   // distance to -AMP
);
  localparam logic signed [DIFF_W-1:0] AMP_S = DIFF_W'(AMP);

  logic signed [DIFF_W-1:0] obs_x, d_one, d_zero;
  logic signed [SQ_W-1:0]   e_one, e_zero, p_one, p_zero;

  always_comb begin
    obs_x  = {obs[SAMPLE_W-1], obs};
    d_one  = obs_x - AMP_S;
    d_zero = obs_x + AMP_S;
    e_one  = {{(SQ_W-DIFF_W){d_one[DIFF_W-1]}}, d_one};
    e_zero = {{(SQ_W-DIFF_W){d_zero[DIFF_W-1]}}, d_zero};
    p_one  = e_one * e_one;
    p_zero = e_zero * e_zero;
    sq_one  = p_one;
    sq_zero = p_zero;
  end
endmodule

// File: rtl/cand_metric.sv
`timescale 1ns/1ps
// One candidate: pick the squares its hypothesis needs, add them,
// remove the a priori term and clamp to the metric width.
module cand_metric #(
  parameter int SAMPLE_W = 16,
  parameter int METRIC_W = 32,
  parameter bit U        = 1'b0,
  parameter bit P        = 1'b0,
  localparam int SQ_W    = 2 * (SAMPLE_W + 1),
  localparam int SUM_W   = SQ_W + 3
) (
  input  logic [2:0][SQ_W-1:0]        sq_one,
  input  logic [2:0][SQ_W-1:0]        sq_zero,
  input  logic signed [SAMPLE_W-1:0]  apri,
  output logic [METRIC_W-1:0]         metric
);
  localparam logic signed [SUM_W-1:0] MAXV = (SUM_W'(1) <<< (METRIC_W-1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] MINV = SUM_W'(0) - (SUM_W'(1) <<< (METRIC_W-1));

  logic signed [SUM_W-1:0] t_sys, t_p1, t_p2, a_ext, a_term, total;

  always_comb begin
    t_sys  = {{(SUM_W-SQ_W){1'b0}}, (U ? sq_one[0] : sq_zero[0])};
    t_p1   = {{(SUM_W-SQ_W){1'b0}}, (P ? sq_one[1] : sq_zero[1])};
    t_p2   = {{(SUM_W-SQ_W){1'b0}}, (P ? sq_one[2] : sq_zero[2])};
    a_ext  = {{(SUM_W-SAMPLE_W){apri[SAMPLE_W-1]}}, apri};
    a_term = U ? a_ext : (SUM_W'(0) - a_ext);
    total  = t_sys + t_p1 + t_p2 - a_term;
    if (total > MAXV)      metric = MAXV[METRIC_W-1:0];
    else if (total < MINV) metric = MINV[METRIC_W-1:0];
    else                   metric = total[METRIC_W-1:0];
  end
endmodule

// File: rtl/euclid_bmu.sv
`timescale 1ns/1ps
module euclid_bmu #(
  parameter int SAMPLE_W = 16,
  parameter int METRIC_W = 32,
  parameter int AMP      = 100,
  parameter int MEM_LEN  = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [SAMPLE_W-1:0]                   sys_sm,
  input  logic [SAMPLE_W-1:0]                   par1_sm,
  input  logic [SAMPLE_W-1:0]                   par2_sm,
  input  logic [SAMPLE_W-1:0]                   apri_sm,
  output logic                                  out_valid,
  output logic [(2<<MEM_LEN)*METRIC_W-1:0]      metrics
);
  localparam int NUM_OBS    = 3;
  localparam int NUM_STATES = 1 << MEM_LEN;
  localparam int NUM_CAND   = 2 * NUM_STATES;
  localparam int SQ_W       = 2 * (SAMPLE_W + 1);

  // ---- stage 1: decode samples and square against both symbols ----
  logic [NUM_OBS-1:0][SAMPLE_W-1:0] obs_sm;
  logic [NUM_OBS-1:0][SAMPLE_W-1:0] obs_tc;
  logic [NUM_OBS-1:0][SQ_W-1:0]     one_d, zero_d, one_q, zero_q;
  logic signed [SAMPLE_W-1:0]       apri_d, apri_q;
  logic                             s1_valid;

  assign obs_sm = {par2_sm, par1_sm, sys_sm};

  for (genvar o = 0; o < NUM_OBS; o++) begin : g_obs
    logic signed [SAMPLE_W-1:0] tc;
    sm_to_tc #(.W(SAMPLE_W)) u_conv (.sm(obs_sm[o]), .tc(tc));
    assign obs_tc[o] = tc;
    obs_sq #(.SAMPLE_W(SAMPLE_W), .AMP(AMP)) u_sq (
      .obs     (tc),
      .sq_one  (one_d[o]),
      .sq_zero (zero_d[o])
    );
  end

  sm_to_tc #(.W(SAMPLE_W)) u_apri (.sm(apri_sm), .tc(apri_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_q  <= '0;
      zero_q <= '0;
      apri_q <= '0;
    end else if (in_valid) begin
      one_q  <= one_d;
      zero_q <= zero_d;
      apri_q <= apri_d;
    end
  end

  // ---- stage 2: per-candidate sum, a priori removal, clamp ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end

  for (genvar k = 0; k < NUM_CAND; k++) begin : g_cand
    localparam euclid_bmu_pkg::code_bits_t CB = euclid_bmu_pkg::cand_code(k, MEM_LEN);
    localparam bit CU = CB.u;
    localparam bit CP = CB.p;
    logic [METRIC_W-1:0] met_d, met_q;

    cand_metric #(
      .SAMPLE_W (SAMPLE_W),
      .METRIC_W (METRIC_W),
      .U        (CU),
      .P        (CP)
    ) u_cm (
      .sq_one  (one_q),
      .sq_zero (zero_q),
      .apri    (apri_q),
      .metric  (met_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        met_q <= '0;
      else if (s1_valid) met_q <= met_d;
    end

    assign metrics[k*METRIC_W +: METRIC_W] = met_q;
  end
endmodule

// File: rtl/euclid_bmu_chk.sv
`timescale 1ns/1ps
module euclid_bmu_chk #(
  parameter int METRIC_W = 32,
  parameter int MEM_LEN  = 2,
  localparam int NUM_CAND = 2 << MEM_LEN
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         out_valid,
  input logic [NUM_CAND*METRIC_W-1:0] metrics
);
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R7
  origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 $stable(metrics));

  for (genvar a = 0; a < NUM_CAND; a++) begin : g_a
    for (genvar b = a + 1; b < NUM_CAND; b++) begin : g_b
      localparam euclid_bmu_pkg::code_bits_t CA = euclid_bmu_pkg::cand_code(a, MEM_LEN);
      localparam euclid_bmu_pkg::code_bits_t CB = euclid_bmu_pkg::cand_code(b, MEM_LEN);
      if (CA == CB) begin : g_same
        // R10
        pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> (metrics[a*METRIC_W +: METRIC_W] == metrics[b*METRIC_W +: METRIC_W]));
      end
    end
  end
endmodule

bind euclid_bmu euclid_bmu_chk #(
  .METRIC_W (METRIC_W),
  .MEM_LEN  (MEM_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .metrics   (metrics)
);

// File: tb/test_euclid_bmu.sv
`timescale 1ns/1ps
module test_euclid_bmu;
  localparam real CLK_PER = 5.0;
  localparam int  NV = 7;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [15:0]  sys_sm, par1_sm, par2_sm, apri_sm;
  logic         out_valid;
  logic [255:0] metrics;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PER/2) clk = ~clk;

  euclid_bmu i_euclid_bmu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .sys_sm(sys_sm), .par1_sm(par1_sm), .par2_sm(par2_sm), .apri_sm(apri_sm),
    .out_valid(out_valid), .metrics(metrics)
  );

  // {sys, par1, par2, a priori}, all sign-magnitude
  localparam logic [63:0] TBL [NV] = '{
    64'h8064_8064_8064_0000,   // ideal all-zero symbols
    64'h0064_0064_0064_0000,   // ideal all-one symbols
    64'h801E_0064_8064_0000,   // -30 as 0x801E
    64'h001E_0032_8032_0019,   // a priori +25
    64'h8000_0000_8000_8019,   // negative zeros, a priori -25
    64'h7FFF_7FFF_7FFF_0000,   // full scale: clamp
    64'h0000_0000_0000_7FFF    // full-scale a priori
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:    return "R2";
      2, 4:    return "R1";
      3:       return "R3";
      5:       return "R6";
      default: return "R4";
    endcase
  endfunction

  function automatic longint sm_val(input logic [15:0] v);
    longint m = longint'(v[14:0]);
    return v[15] ? -m : m;
  endfunction

  function automatic longint model(input logic [63:0] v, input int k);
    longint s  = sm_val(v[63:48]);
    longint p1 = sm_val(v[47:32]);
    longint p2 = sm_val(v[31:16]);
    longint ap = sm_val(v[15:0]);
    int u  = k & 1;
    int s0 = (k >> 1) & 1;
    int s1 = (k >> 2) & 1;
    int a  = u ^ s1 ^ s0;
    int p  = a ^ s0;
    longint hu = u ? 100 : -100;
    longint hp = p ? 100 : -100;
    longint d  = (s-hu)*(s-hu) + (p1-hp)*(p1-hp) + (p2-hp)*(p2-hp) - (u ? ap : -ap);
    if (d > 64'sd2147483647)  d = 64'sd2147483647;
    if (d < -64'sd2147483648) d = -64'sd2147483648;
    return d;
  endfunction

  function automatic longint got(input int k);
    return longint'($signed(metrics[k*32 +: 32]));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] v, input logic vld);
    {sys_sm, par1_sm, par2_sm, apri_sm} = v;
    in_valid = vld;
  endtask

  task automatic check_vec(input logic [63:0] v, input string req);
    chk(out_valid == 1'b1, "R7 out_valid", longint'(out_valid), 1);
    for (int k = 0; k < 8; k++) begin
      chk(got(k) == model(v, k), $sformatf("%s cand %0d", req, k), got(k), model(v, k));
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(64'h0064_0064_0064_0064, 1'b1);
    repeat (3) @(negedge clk);
    // R9: reset holds outputs cleared even with in_valid high
    chk(out_valid == 1'b0, "R9 reset out_valid", longint'(out_valid), 0);
    chk(metrics == '0, "R9 reset metrics", got(0), 0);
    drive(64'h0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle after reset", longint'(out_valid), 0);
    chk(metrics == '0, "R9 metrics after reset", got(1), 0);

    // table walk, back-to-back steps (R7 streaming)
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check_vec(TBL[i-2], tag_of(i-2));
      if (i < NV) drive(TBL[i], 1'b1);
      else        drive(64'h1234_5678_9ABC_DEF0, 1'b0);
    end

    // R8: junk with in_valid low leaves results untouched
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      drive(64'h0ABC_8123_7001_0F0F + 64'(c), 1'b0);
      chk(out_valid == 1'b0, "R8 idle out_valid", longint'(out_valid), 0);
      chk(got(0) == model(TBL[NV-1], 0), "R8 hold cand 0", got(0), model(TBL[NV-1], 0));
      chk(got(7) == model(TBL[NV-1], 7), "R8 hold cand 7", got(7), model(TBL[NV-1], 7));
    end

    // single step: R5 example, R3 mapping, R10 pairs, R7 timing
    @(negedge clk);
    drive(64'h001E_0064_0064_0000, 1'b1);
    @(negedge clk);
    drive(64'h0, 1'b0);
    chk(out_valid == 1'b0, "R7 one edge early", longint'(out_valid), 0);
    @(negedge clk);
    chk(metrics[63:32] == 32'h0000_1324, "R5 distance 70 in slot 1",
        longint'(metrics[63:32]), 64'h1324);
    check_vec(64'h001E_0064_0064_0000, "R3");
    chk(got(0) == got(2), "R10 pair 0/2", got(0), got(2));
    chk(got(1) == got(3), "R10 pair 1/3", got(1), got(3));
    chk(got(4) == got(6), "R10 pair 4/6", got(4), got(6));
    chk(got(5) == got(7), "R10 pair 5/7", got(5), got(7));
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 single pulse", longint'(out_valid), 0);

    // R9: reset while a step is in flight
    drive(64'h0064_8064_0064_0010, 1'b1);
    @(negedge clk);
    drive(64'h0, 1'b0);
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R9 mid-flight out_valid", longint'(out_valid), 0);
    chk(metrics == '0, "R9 mid-flight metrics", got(1), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R9 step lost after reset", longint'(out_valid), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule